// File: doc/BRIEF.md
# Framebuffer Word Fill Engine

This block fills a run of framebuffer words with one repeated 16-bit value. A host sets it up through three small registers: a run length, a start address and a fill value. Writing the length and the start address only stores them. Writing the fill value starts the run. The engine then drives a synchronous RAM write port and writes one word per clock cycle. It always targets the framebuffer that is not on display, which is the inverse of the frame-select input.

The address moves forward only within the low byte. The upper address byte stays fixed, so a run wraps around inside its 256-word row and never crosses into the next row. The start register advances as each word is written. When the run ends it therefore points at the word that follows the last one written, and a second fill-value write continues from there. A busy output covers the run. While busy is high, register writes are discarded.

Top module: `fill_engine`

## Requirements
- R1: After reset, busy and ram_we are 0 and the length, start and fill-value registers read 0.
- R2: A write to offset 4 loads the length register from bits [7:0] of the write data. The upper byte of the write data is discarded.
- R3: A write to offset 6 stores the 16-bit start address. It causes no RAM write and does not raise busy.
- R4: A write to offset 8 with a non-zero length L stores the fill value. It writes exactly L words, one per cycle, in the L cycles that follow the write cycle. Every word carries the fill value, and busy is high in exactly those cycles.
- R5: Consecutive words of one run go to {A[15:8], A[7:0]+1 mod 256}. The upper address byte never changes, so a run that starts at low byte 0xFD goes to 0xFD, 0xFE, 0xFF, 0x00, and so on.
- R6: ram_bank equals the inverse of frame_sel as sampled in the cycle of the fill-value write, and stays constant for the whole run.
- R7: After a run, the start register reads {A[15:8], (A[7:0]+L) mod 256}, the fill-value register reads the fill value, and the length register is unchanged.
- R8: A fill-value write with length 0 writes no word and does not raise busy. It leaves the start register unchanged and stores the fill value.
- R9: Any register write accepted while busy is high is discarded. The run in progress continues unchanged.
- R10: Writes to any offset other than 4, 6 or 8 change no register and start no run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_off | input | 4 | Register byte offset (4 length, 6 start, 8 fill value) |
| reg_wr_data | input | 16 | Register write data |
| frame_sel | input | 1 | Framebuffer currently on display |
| busy | output | 1 | Run in progress |
| ram_we | output | 1 | RAM write enable |
| ram_bank | output | 1 | Target framebuffer for the write |
| ram_addr | output | 16 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| cfg_len | output | 8 | Length register contents |
| cfg_start | output | 16 | Start register contents |
| cfg_data | output | 16 | Fill-value register contents |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 16-bit word, an 8-bit length and an 8-bit row wrap. With these values the full length of 255 and a start near the row end are both in reach within a short run. This lets one run exercise the low-byte wrap and the row boundary, and a maximal run finishes in a few hundred cycles. Runs that begin at 0xFD and at 0x00 show that the address wraps to 0x00 while the upper byte stays the same.

// File: rtl/fill_pkg.sv
package fill_pkg;

    localparam int unsigned REG_OFF_W = 4;

    localparam logic [REG_OFF_W-1:0] OFF_LEN   = 4'd4;
    localparam logic [REG_OFF_W-1:0] OFF_START = 4'd6;
    localparam logic [REG_OFF_W-1:0] OFF_DATA  = 4'd8;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_LEN   = 2'd1,
        SEL_START = 2'd2,
        SEL_DATA  = 2'd3
    } fill_sel_e;

    function automatic fill_sel_e decode_off(input logic [REG_OFF_W-1:0] off);
        fill_sel_e sel;
        case (off)
            OFF_LEN:   sel = SEL_LEN;
            OFF_START: sel = SEL_START;
            OFF_DATA:  sel = SEL_DATA;
            default:   sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/fill_regs.sv
module fill_regs
    import fill_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LEN_W  = 8,
    parameter int unsigned ROW_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_OFF_W-1:0] wr_off,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 busy,
    input  logic                 step,
    output logic                 fire,
    output logic [LEN_W-1:0]     len_q,
    output logic [ADDR_W-1:0]    start_q,
    output logic [DATA_W-1:0]    data_q
);
    fill_sel_e            sel;
    logic                 accept;
    logic [ADDR_W-1:0]    addr_next;

    assign sel    = decode_off(wr_off);
    assign accept = wr_en && !busy;
    assign fire   = accept && (sel == SEL_DATA);

    // Advance only inside the row field; upper bits are held.
    generate
        if (ROW_W >= ADDR_W) begin : g_full_wrap
            assign addr_next = start_q + 1'b1;
        end else begin : g_row_wrap
            logic [ROW_W-1:0] row_lo;
            assign row_lo    = start_q[ROW_W-1:0] + 1'b1;
            assign addr_next = {start_q[ADDR_W-1:ROW_W], row_lo};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q   <= '0;
            start_q <= '0;
            data_q  <= '0;
        end else begin
            if (accept && sel == SEL_LEN)   len_q   <= wr_data[LEN_W-1:0];
            if (accept && sel == SEL_START) start_q <= wr_data[ADDR_W-1:0];
            if (accept && sel == SEL_DATA)  data_q  <= wr_data;
            if (step)                       start_q <= addr_next;
        end
    end

endmodule

// File: rtl/fill_seq.sv
module fill_seq #(
    parameter int unsigned LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [LEN_W-1:0] len,
    input  logic             frame_sel,
    output logic             busy,
    output logic             bank,
    output logic             step
);
    logic [LEN_W-1:0] remain_q;
    logic             last;

    assign step = busy;
    assign last = (remain_q == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            bank     <= 1'b0;
            remain_q <= '0;
        end else if (busy) begin
            remain_q <= remain_q - 1'b1;
            if (last) busy <= 1'b0;
        end else if (fire && len != '0) begin
            busy     <= 1'b1;
            remain_q <= len;
            bank     <= ~frame_sel;
        end
    end

endmodule

// File: rtl/fill_engine.sv
module fill_engine
    import fill_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LEN_W  = 8,
    parameter int unsigned ROW_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr_en,
    input  logic [REG_OFF_W-1:0] reg_wr_off,
    input  logic [DATA_W-1:0]    reg_wr_data,
    input  logic                 frame_sel,
    output logic                 busy,
    output logic                 ram_we,
    output logic                 ram_bank,
    output logic [ADDR_W-1:0]    ram_addr,
    output logic [DATA_W-1:0]    ram_wdata,
    output logic [LEN_W-1:0]     cfg_len,
    output logic [ADDR_W-1:0]    cfg_start,
    output logic [DATA_W-1:0]    cfg_data
);
    logic fire;
    logic step;

    fill_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .ROW_W(ROW_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_off  (reg_wr_off),
        .wr_data (reg_wr_data),
        .busy    (busy),
        .step    (step),
        .fire    (fire),
        .len_q   (cfg_len),
        .start_q (cfg_start),
        .data_q  (cfg_data)
    );

    fill_seq #(
        .LEN_W(LEN_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .len       (cfg_len),
        .frame_sel (frame_sel),
        .busy      (busy),
        .bank      (ram_bank),
        .step      (step)
    );

    assign ram_we    = step;
    assign ram_addr  = cfg_start;
    assign ram_wdata = cfg_data;

endmodule

// File: rtl/fill_engine_chk.sv
module fill_engine_chk
    import fill_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LEN_W  = 8,
    parameter int unsigned ROW_W  = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_wr_en,
    input logic [REG_OFF_W-1:0] reg_wr_off,
    input logic                 busy,
    input logic                 ram_we,
    input logic                 ram_bank,
    input logic [ADDR_W-1:0]    ram_addr,
    input logic [DATA_W-1:0]    ram_wdata,
    input logic [LEN_W-1:0]     cfg_len,
    input logic [ADDR_W-1:0]    cfg_start,
    input logic [DATA_W-1:0]    cfg_data
);
    logic data_wr_idle;
    assign data_wr_idle = reg_wr_en && !busy && (reg_wr_off == OFF_DATA);

    p_start_run_r4: assert property (@(posedge clk) disable iff (rst)
        data_wr_idle && cfg_len != '0 |=> busy && ram_we && ram_addr == $past(cfg_start));

    p_value_hold_r4: assert property (@(posedge clk) disable iff (rst)
        ram_we && $past(ram_we) |-> $stable(ram_wdata));

    p_row_step_r5: assert property (@(posedge clk) disable iff (rst)
        ram_we && $past(ram_we) |->
            ram_addr[ADDR_W-1:ROW_W] == $past(ram_addr[ADDR_W-1:ROW_W]) &&
            ram_addr[ROW_W-1:0] == ROW_W'($past(ram_addr[ROW_W-1:0]) + 1'b1));

    p_bank_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ram_we && $past(ram_we) |-> $stable(ram_bank));

    p_start_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en && !busy && reg_wr_off == OFF_START |=> !busy && !ram_we);

    p_zero_len_r8: assert property (@(posedge clk) disable iff (rst)
        data_wr_idle && cfg_len == '0 |=> !busy && $stable(cfg_start));

    p_busy_lock_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_len) && $stable(cfg_data));

endmodule

bind fill_engine fill_engine_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .ROW_W(ROW_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr_en  (reg_wr_en),
    .reg_wr_off (reg_wr_off),
    .busy       (busy),
    .ram_we     (ram_we),
    .ram_bank   (ram_bank),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .cfg_len    (cfg_len),
    .cfg_start  (cfg_start),
    .cfg_data   (cfg_data)
);

// File: tb/tb_fill_engine.sv
module tb_fill_engine;

    typedef struct packed {
        logic        bank;
        logic [15:0] addr;
        logic [15:0] data;
    } wr_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_wr_off = '0;
    logic [15:0] reg_wr_data = '0;
    logic        frame_sel = 1'b0;
    logic        busy, ram_we, ram_bank;
    logic [15:0] ram_addr, ram_wdata, cfg_start, cfg_data;
    logic [7:0]  cfg_len;

    int checks = 0;
    int errors = 0;
    wr_item_t exp_q[$];

    always #5 clk = ~clk;

    fill_engine dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_off(reg_wr_off),
        .reg_wr_data(reg_wr_data), .frame_sel(frame_sel), .busy(busy),
        .ram_we(ram_we), .ram_bank(ram_bank), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .cfg_len(cfg_len), .cfg_start(cfg_start),
        .cfg_data(cfg_data)
    );

    task automatic check(input bit ok, input string req, input logic [47:0] act,
                         input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: every RAM write must match the head of the scoreboard (R4 R5 R6).
    always @(negedge clk) begin
        if (!rst && ram_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected write", {15'd0, ram_bank, ram_addr, ram_wdata}, 48'd0);
            end else begin
                wr_item_t e;
                e = exp_q.pop_front();
                check({ram_bank, ram_addr, ram_wdata} == e, "R4/R5/R6 write",
                      {15'd0, ram_bank, ram_addr, ram_wdata}, {15'd0, e});
            end
        end
    end

    task automatic reg_write(input logic [3:0] off, input logic [15:0] d);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_off  = off;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    // Driver: programs a run, queues the expected words, waits for the end.
    task automatic run_fill(input logic [7:0] len, input logic [15:0] start,
                            input logic [15:0] val, input logic fsel, input string req);
        logic [15:0] a;
        reg_write(4'd4, {8'h00, len});
        reg_write(4'd6, start);
        frame_sel = fsel;
        a = start;
        for (int i = 0; i < len; i++) begin
            exp_q.push_back('{bank: ~fsel, addr: a, data: val});
            a = {a[15:8], a[7:0] + 8'd1};
        end
        reg_write(4'd8, val);
        check(busy == (len != 0), {req, " busy after start"}, 48'(busy), 48'(len != 0));
        while (busy) @(negedge clk);
        check(exp_q.size() == 0, {req, " all words written"}, 48'(exp_q.size()), 48'd0);
        check(cfg_start == a, {req, " R7 start after run"}, 48'(cfg_start), 48'(a));
        check(cfg_data == val, {req, " R7 value kept"}, 48'(cfg_data), 48'(val));
        check(cfg_len == len, {req, " R7 length kept"}, 48'(cfg_len), 48'(len));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 48'd0, 48'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !ram_we, "R1 idle", 48'({busy, ram_we}), 48'd0);
        check(cfg_len == 0 && cfg_start == 0 && cfg_data == 0, "R1 regs",
              {cfg_len, cfg_start, cfg_data}, 48'd0);

        // R2 low byte only
        reg_write(4'd4, 16'hAB07);
        check(cfg_len == 8'h07, "R2 length low byte", 48'(cfg_len), 48'h07);

        // R3 start write is quiet
        reg_write(4'd6, 16'h1200);
        check(cfg_start == 16'h1200 && !busy, "R3 start stored",
              {31'd0, busy, cfg_start}, 48'h1200);

        run_fill(8'd7, 16'h1200, 16'hBEEF, 1'b0, "R4 basic");
        run_fill(8'd5, 16'h34FD, 16'h5A5A, 1'b1, "R5 wrap");
        run_fill(8'd1, 16'h0A00, 16'hC3C3, 1'b1, "R4 single");

        // R8 zero length
        run_fill(8'd0, 16'h4321, 16'h1111, 1'b0, "R8 zero");
        check(cfg_start == 16'h4321, "R8 start unchanged", 48'(cfg_start), 48'h4321);

        run_fill(8'd255, 16'h7700, 16'h0F0F, 1'b0, "R5 full row");

        // R9 writes during busy are dropped
        reg_write(4'd4, 16'd20);
        reg_write(4'd6, 16'h2000);
        frame_sel = 1'b1;
        for (int i = 0; i < 20; i++)
            exp_q.push_back('{bank: 1'b0, addr: 16'h2000 + 16'(i), data: 16'hAAAA});
        reg_write(4'd8, 16'hAAAA);
        reg_write(4'd4, 16'd3);
        reg_write(4'd6, 16'h9999);
        reg_write(4'd8, 16'h5555);
        check(busy, "R9 run continues", 48'(busy), 48'd1);
        check(cfg_len == 8'd20 && cfg_data == 16'hAAAA, "R9 regs held",
              {8'd0, cfg_len, 16'd0, cfg_data}, {8'd0, 8'd20, 16'd0, 16'hAAAA});
        while (busy) @(negedge clk);
        check(exp_q.size() == 0, "R9 words written", 48'(exp_q.size()), 48'd0);
        check(cfg_start == 16'h2014, "R9 start final", 48'(cfg_start), 48'h2014);

        // R10 unmapped offsets
        reg_write(4'd2, 16'hFFFF);
        reg_write(4'd10, 16'hFFFF);
        reg_write(4'd0, 16'hFFFF);
        reg_write(4'd5, 16'hFFFF);
        @(negedge clk);
        check(!busy && cfg_len == 8'd20 && cfg_start == 16'h2014 && cfg_data == 16'hAAAA,
              "R10 regs unchanged", {7'd0, busy, cfg_len, cfg_start, cfg_data},
              {8'd0, 8'd20, 16'h2014, 16'hAAAA});
        check(exp_q.size() == 0, "R10 no stray run", 48'(exp_q.size()), 48'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule